// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block holds the program counter of a small core with 16-bit instruction words and fetches from a synchronous program memory. The memory returns a word one cycle after it sees an address. Each word fetched falls into one of three kinds. A single-word instruction is issued at once. The first word of a two-word instruction is held back. An operand word, whose top nibble is all ones, either completes the held instruction with its low 12 bits or is issued as a no-operation when it arrives on its own.

Two kinds of control flow are handled here:
- A test-for-zero instruction turns the next fetched word into a no-operation when the tested register is zero. That register is outside the block, so its zero status arrives on an input.
- A computed jump adds a byte offset from the working register to the low byte of the program counter.

Decoding beyond these classes, the ALU, data memory and the return stack are handled by other blocks.

Top module: `twoword_fetch`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0, `iss_valid` is low after that edge, and any held first word and pending skip are discarded.
- R2: The program counter is a byte address with bit 0 always 0. It is held on `mem_addr` for two cycles per word and then advances by 2. Sampled after each edge that follows reset release, the sequence is 0, 2, 2, 4, 4, ...
- R3: A single-word instruction is issued with `iss_valid` high for exactly one cycle. It carries `iss_op` equal to the word, `iss_ext` equal to 0, `iss_nop` equal to 0 and `iss_pc` equal to its own address.
- R4: A first word is held without being issued. The recognised first words are: top nibble 1100 (register move), top 7 bits 1110110 (call), top byte 1110 1111 (goto), and top 10 bits 1110 1110 00 (pointer load). The next word, if it has top nibble 1111, completes the held word. The issue then carries the held word, `iss_ext` set to that word's low 12 bits, and `iss_pc` set to the first word's address.
- R5: A word with top nibble 1111 that follows no held first word is issued as a no-operation: `iss_nop` is 1, and `iss_op` and `iss_ext` are 0.
- R6: A test word (top 7 bits 0110011) is issued normally. If `tst_zero` is high when the word arrives, the next word fetched is issued as a no-operation, whatever its kind. If `tst_zero` is low, nothing is skipped.
- R7: A skip that lands on a first word turns it into a no-operation. The operand word that follows then arrives alone and becomes a second no-operation, so bypassing a two-word instruction costs two no-op issues.
- R8: The word 0x26F9 (computed jump) is issued and then reloads the program counter. The new low byte is the low byte of (its address + 2) plus `wreg`, with bit 0 cleared and no carry into the upper bits. The upper bits stay those of its address + 2.
- R9: A held first word followed by a word whose top nibble is not 1111 is discarded, and the new word is handled as if nothing were held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | PC_W | Byte address to the program memory |
| mem_rdata | input | 16 | Word read, valid one cycle after its address |
| wreg | input | 8 | Byte offset for the computed jump |
| tst_zero | input | 1 | High when the register under test is zero |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_nop | output | 1 | Issue is a no-operation |
| iss_op | output | 16 | Opcode word issued |
| iss_ext | output | 12 | Operand from the continuation word |
| iss_pc | output | PC_W | Address of the issued instruction |

## Verification
The checker assumes a memory that returns data exactly one cycle after the address and never an unknown word. It also assumes that `tst_zero` and `wreg` are stable while a test or jump word is being decoded. The bench keeps both inputs constant for the whole of each scenario. Its memory model registers the word at every edge. Programs are short enough that every reachable address lies inside the 256-word model, which is filled with plain single-word instructions.

// File: rtl/twoword_fetch.sv
module twoword_fetch #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] mem_addr,
  input  logic [15:0]     mem_rdata,
  input  logic [7:0]      wreg,
  input  logic            tst_zero,
  output logic            iss_valid,
  output logic            iss_nop,
  output logic [15:0]     iss_op,
  output logic [11:0]     iss_ext,
  output logic [PC_W-1:0] iss_pc
);
  localparam logic [15:0] JMP_WORD = 16'h26F9;

  logic [PC_W-1:0] pc, pc_nx, pend_pc;
  logic [15:0]     pend_op;
  logic            ph, pend, skip;
  logic            is_cont, is_first, is_tst, is_jmp;
  logic [7:0]      jmp_lo;

  assign mem_addr = pc;
  assign pc_nx    = pc + PC_W'(2);
  assign is_cont  = mem_rdata[15:12] == 4'hF;
  assign is_first = (mem_rdata[15:12] == 4'hC) || (mem_rdata[15:9] == 7'b1110110) ||
                    (mem_rdata[15:8] == 8'hEF) || (mem_rdata[15:6] == 10'b1110111000);
  assign is_tst   = mem_rdata[15:9] == 7'b0110011;
  assign is_jmp   = mem_rdata == JMP_WORD;
  assign jmp_lo   = (pc_nx[7:0] + wreg) & 8'hFE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; ph <= 1'b0; pend <= 1'b0; skip <= 1'b0;
      pend_op <= '0; pend_pc <= '0;
      iss_valid <= 1'b0; iss_nop <= 1'b0; iss_op <= '0; iss_ext <= '0; iss_pc <= '0;
    end else begin
      iss_valid <= 1'b0;
      iss_nop   <= 1'b0;
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        pc <= pc_nx;
        if (skip || (is_cont && !pend)) begin
          skip <= 1'b0; pend <= 1'b0;
          iss_valid <= 1'b1; iss_nop <= 1'b1;
          iss_op <= '0; iss_ext <= '0; iss_pc <= pc;
        end else if (is_cont) begin
          pend <= 1'b0;
          iss_valid <= 1'b1;
          iss_op <= pend_op; iss_ext <= mem_rdata[11:0]; iss_pc <= pend_pc;
        end else if (is_first) begin
          pend <= 1'b1; pend_op <= mem_rdata; pend_pc <= pc;
        end else begin
          pend <= 1'b0;
          iss_valid <= 1'b1;
          iss_op <= mem_rdata; iss_ext <= '0; iss_pc <= pc;
          if (is_tst && tst_zero) skip <= 1'b1;
          if (is_jmp) pc <= {pc_nx[PC_W-1:8], jmp_lo};
        end
      end
    end
  end
endmodule

module twoword_fetch_chk #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] mem_addr,
  input logic            iss_valid,
  input logic            iss_nop,
  input logic [15:0]     iss_op,
  input logic [11:0]     iss_ext
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (mem_addr == '0 && !iss_valid));

  p_pc_even_r2: assert property (@(posedge clk) disable iff (rst) mem_addr[0] == 1'b0);

  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |->
      (mem_addr == $past(mem_addr) + PC_W'(2)) || (iss_valid && iss_op == 16'h26F9));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst) iss_valid |=> !iss_valid);

  p_nop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_nop) |-> (iss_op == 16'h0 && iss_ext == 12'h0));

  p_ext_twoword_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_nop && iss_ext != 12'h0) |-> (iss_op[15:12] == 4'hC || iss_op[15:12] == 4'hE));
endmodule

bind twoword_fetch twoword_fetch_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .iss_valid(iss_valid),
  .iss_nop(iss_nop), .iss_op(iss_op), .iss_ext(iss_ext)
);

// File: tb/sim_twoword_fetch.sv
`timescale 1ns/1ps
module sim_twoword_fetch;
  localparam int PC_W = 21;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [PC_W-1:0] mem_addr, iss_pc;
  logic [15:0] mem_rdata, iss_op;
  logic [11:0] iss_ext;
  logic [7:0]  wreg = 8'h0;
  logic tst_zero = 1'b0, iss_valid, iss_nop;

  twoword_fetch #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wreg(wreg),
    .tst_zero(tst_zero), .iss_valid(iss_valid), .iss_nop(iss_nop), .iss_op(iss_op),
    .iss_ext(iss_ext), .iss_pc(iss_pc)
  );

  logic [15:0] prog [256];
  always @(posedge clk) mem_rdata <= prog[mem_addr[8:1]];

  int n_run = 0, n_fail = 0, got_n = 0, cyc = 0;
  logic [15:0] got_op [64], exp_op [64];
  logic [11:0] got_ext [64], exp_ext [64];
  logic [PC_W-1:0] got_pc [64], exp_pc [64];
  logic got_nop [64], exp_nop [64];

  always @(negedge clk) begin
    cyc++;
    if (!rst && iss_valid && got_n < 64) begin
      got_op[got_n] = iss_op; got_ext[got_n] = iss_ext;
      got_pc[got_n] = iss_pc; got_nop[got_n] = iss_nop;
      got_n++;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", r, what, act, expv);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) prog[i] = 16'h0E00 + 16'(i);
  endtask

  function automatic bit first_word(logic [15:0] w);
    return w[15:12] == 4'b1100 || w[15:9] == 7'b1110110 || w[15:8] == 8'b11101111 ||
           w[15:6] == 10'b1110111000;
  endfunction

  task automatic build_exp(int n);
    logic [PC_W-1:0] pc = '0, pcn, nxt, ppc = '0;
    logic [15:0] w, pop = '0;
    bit pend = 0, skp = 0;
    int k = 0;
    for (int g = 0; g < 1000 && k < n; g++) begin
      w = prog[pc[8:1]]; pcn = pc + 2; nxt = pcn;
      if (skp) begin
        exp_op[k] = 0; exp_ext[k] = 0; exp_pc[k] = pc; exp_nop[k] = 1; k++;
        skp = 0; pend = 0;
      end else if (w[15:12] == 4'b1111) begin
        if (pend) begin exp_op[k] = pop; exp_ext[k] = w[11:0]; exp_pc[k] = ppc; exp_nop[k] = 0; end
        else begin exp_op[k] = 0; exp_ext[k] = 0; exp_pc[k] = pc; exp_nop[k] = 1; end
        k++; pend = 0;
      end else if (first_word(w)) begin
        pend = 1; pop = w; ppc = pc;
      end else begin
        pend = 0;
        exp_op[k] = w; exp_ext[k] = 0; exp_pc[k] = pc; exp_nop[k] = 0; k++;
        if (w[15:9] == 7'b0110011 && tst_zero) skp = 1;
        if (w == 16'h26F9) nxt = {pcn[PC_W-1:8], (pcn[7:0] + wreg) & 8'hFE};
      end
      pc = nxt;
    end
  endtask

  task automatic run(string r, int n);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    got_n = 0;
    rst = 1'b0;
    for (int i = 0; i < n * 8 + 20 && got_n < n; i++) @(negedge clk);
    build_exp(n);
    chk(r, "issue count", 32'(got_n >= n), 32'd1);
    for (int i = 0; i < n; i++) begin
      chk(r, $sformatf("op[%0d]", i), 32'(got_op[i]), 32'(exp_op[i]));
      chk(r, $sformatf("ext[%0d]", i), 32'(got_ext[i]), 32'(exp_ext[i]));
      chk(r, $sformatf("pc[%0d]", i), 32'(got_pc[i]), 32'(exp_pc[i]));
      chk(r, $sformatf("nop[%0d]", i), 32'(got_nop[i]), 32'(exp_nop[i]));
    end
  endtask

  task automatic t_reset_r1();
    fill(); prog[0] = 16'hC001;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "addr in reset", 32'(mem_addr), 32'd0);
    chk("R1", "valid in reset", 32'(iss_valid), 32'd0);
  endtask

  task automatic t_pc_r2();
    fill();
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2", $sformatf("addr step %0d", k), 32'(mem_addr), 32'(2 * ((k + 1) / 2)));
    end
  endtask

  task automatic t_single_r3();
    fill(); tst_zero = 0; run("R3", 5);
  endtask

  task automatic t_twoword_r4();
    fill(); tst_zero = 0;
    prog[0] = 16'hC123; prog[1] = 16'hF456; prog[2] = 16'hEC05; prog[3] = 16'hF007;
    prog[4] = 16'hEF10; prog[5] = 16'hF020; prog[6] = 16'hEE12; prog[7] = 16'hF0AB;
    run("R4", 6);
  endtask

  task automatic t_lone_r5();
    fill(); tst_zero = 0; prog[1] = 16'hF333; run("R5", 3);
  endtask

  task automatic t_tst_r6();
    fill(); tst_zero = 0;
    prog[0] = 16'h6600; prog[1] = 16'hC001; prog[2] = 16'hF002;
    run("R6", 4);
    fill(); tst_zero = 1;
    prog[0] = 16'h6600; prog[1] = 16'h0E11;
    run("R6", 3);
    tst_zero = 0;
  endtask

  task automatic t_skip2_r7();
    fill(); tst_zero = 1;
    prog[0] = 16'h6700; prog[1] = 16'hC001; prog[2] = 16'hF002;
    run("R7", 4);
    tst_zero = 0;
  endtask

  task automatic t_jump_r8();
    fill(); tst_zero = 0; prog[0] = 16'h26F9;
    wreg = 8'h08; run("R8", 3);
    wreg = 8'h07; run("R8", 3);
    wreg = 8'hFE; run("R8", 3);
    wreg = 8'h00;
  endtask

  task automatic t_drop_r9();
    fill(); tst_zero = 0;
    prog[0] = 16'hC001; prog[1] = 16'h0E33; prog[2] = 16'hF044;
    run("R9", 3);
  endtask

  initial begin
    fill();
    t_reset_r1();
    t_pc_r2();
    t_single_r3();
    t_twoword_r4();
    t_lone_r5();
    t_tst_r6();
    t_skip2_r7();
    t_jump_r8();
    t_drop_r9();
    summary();
  end
endmodule